// File: doc/BRIEF.md
# Double-Buffered Frame Parameter Bank

This block is a small register file on a single-clock parameter bus. Software writes a frame width and a frame height, each stored as size minus one. It also writes a keep flag and an update flag. Writes land in shadow registers. While the update flag is set, the shadow registers are locked.

The next input frame-start strobe copies the shadow values into working registers and clears the update flag. The core therefore never sees a half-written configuration.

The working values go to the video core together with a registered copy of the frame-start strobe. That strobe is aligned with any newly committed values. A second pair of outputs captures the working frame size whenever the output side starts a frame, and holds it for the whole output frame.

Top module: `frame_param_bank`

## Requirements
- R1: After reset the width register holds 719, the height register holds 479, and the keep and update flags read 0. The working registers and the output-frame size ports hold the same values.
- R2: The bus uses byte addresses. 0x00 selects width, 0x04 selects height, 0x08 selects keep (data bit 0) and 0x0C selects update (data bit 0). Values are right-aligned and unused read bits are 0. Addresses of 0x10 and above read 0 and ignore writes. With the 32-bit bus, address bits 1:0 are ignored. With a 16-bit bus, address bit 0 is ignored and address bit 1 set selects an empty upper half.
- R3: Read data after a clock edge holds the register addressed at that edge, with the contents it had before that edge.
- R4: While the update flag is 1, every bus write is ignored, including writes to the update flag itself.
- R5: A width or height write below 63 stores 63. A write above the configured maximum dimension minus one stores that maximum minus one.
- R6: When the input frame-start strobe is high while the update flag is 1, the working width, height and keep take the shadow values after that edge, and the update flag reads 0. At all other times the working values do not change.
- R7: A shadow register not written since the last commit passes its held value into the working registers at the next commit.
- R8: The core frame-start output is the input frame-start strobe delayed by one cycle, so it coincides with any values committed by that strobe.
- R9: When the output frame-start input is high, the output-frame width and height ports take the working values after that edge, and hold them otherwise.
- R10: Writing 0 to the update flag leaves it 0. Setting it in the same cycle as an input frame start does not commit; the commit waits for the next frame start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for bus and core side |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrite | input | 1 | Bus write enable |
| busAddr | input | ADDR_W | Bus byte address |
| busWdata | input | BUS_W | Bus write data |
| busRdata | output | BUS_W | Bus read data, one cycle after the address |
| inFrameStart | input | 1 | Input frame-start strobe |
| outFrameStart | input | 1 | Output frame-start strobe |
| coreFrameStart | output | 1 | Registered input frame start, aligned with working values |
| workWidth | output | DIM_W | Working frame width minus one |
| workHeight | output | DIM_W | Working frame height minus one |
| workKeep | output | 1 | Working keep flag |
| outWidth | output | DIM_W | Width minus one captured at output frame start |
| outHeight | output | DIM_W | Height minus one captured at output frame start |

## Verification
The bench builds the bank with its defaults: a 32-bit bus, 5-bit addresses and a 1920 by 1080 maximum. With 12-bit random write data, both clamp limits are reached often. With a 32-bit bus, random low address bits test that bits 1:0 are ignored. Random addresses at 0x10 and above test the unmapped space. Frequent frame-start strobes make update writes collide with commits, including the same-cycle case.

// File: rtl/frame_param_pkg.sv
package frame_param_pkg;

  localparam logic [1:0] IDX_WIDTH  = 2'd0;
  localparam logic [1:0] IDX_HEIGHT = 2'd1;
  localparam logic [1:0] IDX_KEEP   = 2'd2;
  localparam logic [1:0] IDX_UPDATE = 2'd3;

  typedef struct packed {
    logic       wrWidth;
    logic       wrHeight;
    logic       wrKeep;
    logic       commit;
    logic       pending;
    logic       rdHit;
    logic [1:0] rdIdx;
  } ctrl_t;

endpackage

// File: rtl/frame_param_ctrl.sv
module frame_param_ctrl
  import frame_param_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  input  logic              inFrameStart,
  output logic              coreFrameStart,
  output ctrl_t             ctrl
);

  logic       pendingQ;
  logic       upperZero;
  logic       halfOk;
  logic       hit;
  logic [1:0] idx;
  logic       wrOk;

  assign upperZero = (busAddr[ADDR_W-1:4] == '0);
  assign idx       = busAddr[3:2];

  generate
    if (BUS_W >= 32) begin : g_wide
      assign halfOk = 1'b1;
    end else begin : g_narrow
      assign halfOk = ~busAddr[1];
    end
  endgenerate

  assign hit  = upperZero & halfOk;
  assign wrOk = busWrite & hit & ~pendingQ;

  always_comb begin
    ctrl          = '0;
    ctrl.pending  = pendingQ;
    ctrl.commit   = pendingQ & inFrameStart;
    ctrl.wrWidth  = wrOk & (idx == IDX_WIDTH);
    ctrl.wrHeight = wrOk & (idx == IDX_HEIGHT);
    ctrl.wrKeep   = wrOk & (idx == IDX_KEEP);
    ctrl.rdHit    = hit;
    ctrl.rdIdx    = idx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendingQ       <= 1'b0;
      coreFrameStart <= 1'b0;
    end else begin
      coreFrameStart <= inFrameStart;
      if (pendingQ && inFrameStart)
        pendingQ <= 1'b0;
      else if (wrOk && idx == IDX_UPDATE && busWdata[0])
        pendingQ <= 1'b1;
    end
  end

  AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (pendingQ && inFrameStart) |=> !pendingQ); // R6
  AST_UPDATE_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (pendingQ && !inFrameStart) |=> pendingQ); // R4
  AST_STROBE_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    inFrameStart |=> coreFrameStart); // R8

endmodule

// File: rtl/frame_param_data.sv
module frame_param_data
  import frame_param_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int DIM_W  = 11,
  parameter int MAX_W  = 1920,
  parameter int MAX_H  = 1080,
  parameter int MIN_D  = 63,
  parameter int DEF_W  = 719,
  parameter int DEF_H  = 479
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_t            ctrl,
  input  logic [BUS_W-1:0] busWdata,
  input  logic             outFrameStart,
  output logic [BUS_W-1:0] busRdata,
  output logic [DIM_W-1:0] workWidth,
  output logic [DIM_W-1:0] workHeight,
  output logic             workKeep,
  output logic [DIM_W-1:0] outWidth,
  output logic [DIM_W-1:0] outHeight
);

  localparam logic [BUS_W-1:0] LO_LIM  = BUS_W'(MIN_D);
  localparam logic [BUS_W-1:0] HI_W    = BUS_W'(MAX_W - 1);
  localparam logic [BUS_W-1:0] HI_H    = BUS_W'(MAX_H - 1);
  localparam logic [DIM_W-1:0] RST_W   = DIM_W'(DEF_W);
  localparam logic [DIM_W-1:0] RST_H   = DIM_W'(DEF_H);

  logic [DIM_W-1:0] shWidth;
  logic [DIM_W-1:0] shHeight;
  logic             shKeep;
  logic [DIM_W-1:0] clampW;
  logic [DIM_W-1:0] clampH;
  logic [BUS_W-1:0] rdNext;

  function automatic logic [DIM_W-1:0] clampDim(input logic [BUS_W-1:0] v,
                                                input logic [BUS_W-1:0] hi);
    if (v < LO_LIM)   return DIM_W'(LO_LIM);
    else if (v > hi)  return DIM_W'(hi);
    else              return DIM_W'(v);
  endfunction

  assign clampW = clampDim(busWdata, HI_W);
  assign clampH = clampDim(busWdata, HI_H);

  always_comb begin
    rdNext = '0;
    if (ctrl.rdHit) begin
      case (ctrl.rdIdx)
        IDX_WIDTH:  rdNext = BUS_W'(shWidth);
        IDX_HEIGHT: rdNext = BUS_W'(shHeight);
        IDX_KEEP:   rdNext = BUS_W'(shKeep);
        default:    rdNext = BUS_W'(ctrl.pending);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shWidth  <= RST_W;
      shHeight <= RST_H;
      shKeep   <= 1'b0;
      busRdata <= '0;
    end else begin
      busRdata <= rdNext;
      if (ctrl.wrWidth)  shWidth  <= clampW;
      if (ctrl.wrHeight) shHeight <= clampH;
      if (ctrl.wrKeep)   shKeep   <= busWdata[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      workWidth  <= RST_W;
      workHeight <= RST_H;
      workKeep   <= 1'b0;
    end else if (ctrl.commit) begin
      workWidth  <= shWidth;
      workHeight <= shHeight;
      workKeep   <= shKeep;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outWidth  <= RST_W;
      outHeight <= RST_H;
    end else if (outFrameStart) begin
      outWidth  <= workWidth;
      outHeight <= workHeight;
    end
  end

  AST_SHADOW_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.pending |=> ($stable(shWidth) && $stable(shHeight) && $stable(shKeep))); // R4
  AST_WORK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.commit |=> ($stable(workWidth) && $stable(workHeight) && $stable(workKeep))); // R6
  AST_SHADOW_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (BUS_W'(shWidth) >= LO_LIM && BUS_W'(shWidth) <= HI_W &&
     BUS_W'(shHeight) >= LO_LIM && BUS_W'(shHeight) <= HI_H)); // R5
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !outFrameStart |=> ($stable(outWidth) && $stable(outHeight))); // R9

endmodule

// File: rtl/frame_param_bank.sv
module frame_param_bank
  import frame_param_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int BUS_W  = 32,
  parameter int MAX_W  = 1920,
  parameter int MAX_H  = 1080,
  parameter int MIN_D  = 63,
  parameter int DEF_W  = 719,
  parameter int DEF_H  = 479,
  localparam int DIM_W = $clog2((MAX_W > MAX_H) ? MAX_W : MAX_H)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  input  logic              inFrameStart,
  input  logic              outFrameStart,
  output logic              coreFrameStart,
  output logic [DIM_W-1:0]  workWidth,
  output logic [DIM_W-1:0]  workHeight,
  output logic              workKeep,
  output logic [DIM_W-1:0]  outWidth,
  output logic [DIM_W-1:0]  outHeight
);

  ctrl_t ctrl;

  frame_param_ctrl #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .busWrite       (busWrite),
    .busAddr        (busAddr),
    .busWdata       (busWdata),
    .inFrameStart   (inFrameStart),
    .coreFrameStart (coreFrameStart),
    .ctrl           (ctrl)
  );

  frame_param_data #(
    .BUS_W(BUS_W), .DIM_W(DIM_W), .MAX_W(MAX_W), .MAX_H(MAX_H),
    .MIN_D(MIN_D), .DEF_W(DEF_W), .DEF_H(DEF_H)
  ) u_data (
    .clk           (clk),
    .rstN          (rstN),
    .ctrl          (ctrl),
    .busWdata      (busWdata),
    .outFrameStart (outFrameStart),
    .busRdata      (busRdata),
    .workWidth     (workWidth),
    .workHeight    (workHeight),
    .workKeep      (workKeep),
    .outWidth      (outWidth),
    .outHeight     (outHeight)
  );

endmodule

// File: tb/frame_param_bank_test.sv
`timescale 1ns/1ps
module frame_param_bank_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrite = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        inFrameStart = 1'b0;
  logic        outFrameStart = 1'b0;
  logic        coreFrameStart;
  logic [10:0] workWidth, workHeight, outWidth, outHeight;
  logic        workKeep;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  int mW, mH, mPend, mK, wW, wH, wK, oW, oH;

  always #2.5 clk = ~clk;

  frame_param_bank uut (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .inFrameStart(inFrameStart),
    .outFrameStart(outFrameStart), .coreFrameStart(coreFrameStart),
    .workWidth(workWidth), .workHeight(workHeight), .workKeep(workKeep),
    .outWidth(outWidth), .outHeight(outHeight)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clampDim(input int v, input int hi);
    if (v < 63) return 63;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic int readModel(input logic [4:0] a);
    if (a[4]) return 0;
    case (a[3:2])
      2'd0: return mW;
      2'd1: return mH;
      2'd2: return mK;
      default: return mPend;
    endcase
  endfunction

  task automatic step(input bit w, input logic [4:0] a, input int d,
                      input bit ifs, input bit ofs);
    int rdExp;
    bit coreExp;
    @(negedge clk);
    busWrite = w; busAddr = a; busWdata = d;
    inFrameStart = ifs; outFrameStart = ofs;
    rdExp = readModel(a);
    coreExp = ifs;
    if (ofs) begin oW = wW; oH = wH; end
    if (ifs && mPend == 1) begin
      wW = mW; wH = mH; wK = mK; mPend = 0;
    end else if (w && mPend == 0 && !a[4]) begin
      case (a[3:2])
        2'd0: mW = clampDim(d, 1919);
        2'd1: mH = clampDim(d, 1079);
        2'd2: mK = d & 1;
        default: if (d[0]) mPend = 1;
      endcase
    end
    @(posedge clk); #1;
    check(busRdata == rdExp, "R3 read data", busRdata, rdExp);
    check(workWidth == wW && workHeight == wH && workKeep == wK,
          "R6 working values", workWidth, wW);
    check(coreFrameStart == coreExp, "R8 core strobe", coreFrameStart, coreExp);
    check(outWidth == oW && outHeight == oH, "R9 output size", outWidth, oW);
  endtask

  task automatic readReg(input logic [4:0] a, input string req, input int exp);
    step(0, a, 0, 0, 0);
    check(busRdata == exp, req, busRdata, exp);
  endtask

  initial begin
    int unused;
    unused = $urandom(32'd2024);
    mW = 719; mH = 479; mK = 0; mPend = 0;
    wW = 719; wH = 479; wK = 0; oW = 719; oH = 479;
    #12 rstN = 1'b1;
    #1;
    check(workWidth == 719 && workHeight == 479 && workKeep == 0, "R1 reset working", workWidth, 719);
    check(outWidth == 719 && outHeight == 479, "R1 reset out size", outWidth, 719);
    readReg(5'h00, "R1 reset width", 719);
    readReg(5'h04, "R1 reset height", 479);
    readReg(5'h08, "R1 reset keep", 0);
    readReg(5'h0C, "R1 reset update", 0);

    step(1, 5'h00, 10, 0, 0);    readReg(5'h00, "R5 low clamp", 63);
    step(1, 5'h00, 9999, 0, 0);  readReg(5'h00, "R5 high clamp width", 1919);
    step(1, 5'h04, 2000, 0, 0);  readReg(5'h04, "R5 high clamp height", 1079);
    step(1, 5'h03, 800, 0, 0);   readReg(5'h00, "R2 low bits ignored", 800);
    step(1, 5'h10, 100, 0, 0);   readReg(5'h10, "R2 unmapped reads zero", 0);
    readReg(5'h00, "R2 unmapped write ignored", 800);
    step(1, 5'h08, 1, 0, 0);
    step(1, 5'h0C, 0, 0, 0);     readReg(5'h0C, "R10 zero keeps update clear", 0);
    step(1, 5'h0C, 1, 1, 0);     readReg(5'h0C, "R10 same-cycle set pending", 1);
    check(workWidth == 719, "R10 no commit same cycle", workWidth, 719);
    step(1, 5'h00, 300, 0, 0);   readReg(5'h00, "R4 width locked", 800);
    step(1, 5'h08, 0, 0, 0);     readReg(5'h08, "R4 keep locked", 1);
    step(0, 5'h00, 0, 1, 0);
    check(workWidth == 800 && workHeight == 1079 && workKeep == 1, "R6 commit", workWidth, 800);
    readReg(5'h0C, "R6 update cleared", 0);
    step(1, 5'h04, 500, 0, 0);
    step(1, 5'h0C, 1, 0, 0);
    step(0, 5'h00, 0, 1, 1);
    check(workWidth == 800 && workHeight == 500, "R7 held width passes", workWidth, 800);
    check(outWidth == 800 && outHeight == 1079, "R9 captured old working", outHeight, 1079);
    step(0, 5'h00, 0, 0, 1);
    check(outHeight == 500, "R9 captured new working", outHeight, 500);

    for (int i = 0; i < 4000; i++) begin
      int r, d;
      logic [4:0] a;
      r = $urandom % 10;
      if (r < 7)       a = 5'({r[1:0], 2'b00} | ($urandom % 4));
      else if (r == 7) a = 5'(16 + $urandom % 16);
      else             a = 5'h0C;
      d = ($urandom % 3 == 0) ? ($urandom % 2) : ($urandom % 4096);
      step($urandom % 3 != 0, a, d, $urandom % 12 == 0, $urandom % 15 == 0);
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule